// File: doc/BRIEF.md
# Width-Matching Synchronous FIFO

This block is a single-clock FIFO whose write port and read port may have different widths. Storage is always made of 36-bit words. A write port narrower than 36 bits gathers several narrow writes into one storage word. A read port narrower than 36 bits hands each stored word out as several narrow pieces. Five width pairings are supported, and a byte-order mode decides which part of a stored word a narrow piece maps to.

The width pairing and the byte order are captured from two configuration inputs on every clock edge while `rst_n` is low. Both stay frozen from the release of reset until the next reset. The read side is show-ahead. Whenever `empty` is low, `rd_data` already carries the current piece, and asserting `rd_en` for one cycle moves on to the next piece.

Top module: `width_match_fifo`

## Requirements
- R1: The pairing on `cfg_bus_sel` and the order on `cfg_big_end` are sampled on each rising clock edge while `rst_n` is low. Changes on those inputs after reset is released have no effect on packing or unpacking.
- R2: With pairing code 0 (36-bit write, 36-bit read), words come out whole and in the order they were written.
- R3: With code 1 (36-bit write, 18-bit read) or code 2 (36-bit write, 9-bit read), each stored word is read as 2 or 4 pieces on the low bits of `rd_data`, and the unused upper bits read as zero. With `cfg_big_end`=1 the most significant piece comes first and each following piece is the next less significant one. With `cfg_big_end`=0 the least significant piece comes first and the order runs upward.
- R4: With code 3 (18-bit write, 36-bit read) or code 4 (9-bit write, 36-bit read), only the low 18 or 9 bits of `wr_data` are used. Each group of 2 or 4 accepted writes forms one stored word. With big-endian order the first write lands in the most significant piece. With little-endian order the first write lands in the least significant piece.
- R5: `empty` stays high until a complete storage word is held. A partly gathered word never clears it.
- R6: `full` is high exactly when DEPTH complete words are held. `full` and `empty` are never high together.
- R7: A write while `full` is high is dropped, including a narrow write, and no stored data changes.
- R8: A read while `empty` is high is dropped, and the next valid word is still the first one read out.
- R9: A narrow read frees its storage word only after the last piece of that word is read. After reading any earlier piece, `full` stays unchanged.
- R10: Directly after reset, `empty` is 1 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous master reset; the configuration is sampled while it is low |
| cfg_bus_sel | input | 3 | Width pairing: 0=36/36, 1=36/18, 2=36/9, 3=18/36, 4=9/36 (write/read); other codes act as 0 |
| cfg_big_end | input | 1 | 1 selects big-endian piece order, 0 selects little-endian |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Write data; narrow modes use the low bits only |
| rd_en | input | 1 | Read strobe; advances to the next piece |
| rd_data | output | 36 | Current piece, zero-extended in narrow read modes |
| full | output | 1 | No complete word can be accepted |
| empty | output | 1 | No complete word is available |

## Verification
Every pairing is run in both byte orders. Each run has three phases: a burst of writes followed by a drain, an interleaved phase where writes and reads share cycles, and a drain with extra reads past the end. A slice-level queue model separates a swapped piece order from a correct one. It also catches pieces shifted into the wrong lane and writes whose upper data bits leak into storage. A fill beyond capacity with 9-bit writes, followed by a single-piece read, tells dropped writes apart from late pointer movement. A configuration change after reset and reads against an empty FIFO show whether the latched mode and the pointers stay put.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int WORD_W  = 36;
  localparam int SLICE_W = WORD_W / 4;
  localparam int HALF_W  = WORD_W / 2;

  typedef enum logic [2:0] {
    BM_W36_R36 = 3'd0,
    BM_W36_R18 = 3'd1,
    BM_W36_R9  = 3'd2,
    BM_W18_R36 = 3'd3,
    BM_W9_R36  = 3'd4
  } bm_mode_e;

  function automatic bm_mode_e legal_mode(logic [2:0] code);
    case (code)
      3'd1:    return BM_W36_R18;
      3'd2:    return BM_W36_R9;
      3'd3:    return BM_W18_R36;
      3'd4:    return BM_W9_R36;
      default: return BM_W36_R36;
    endcase
  endfunction

  function automatic int unsigned wr_pieces(bm_mode_e m);
    case (m)
      BM_W18_R36: return 2;
      BM_W9_R36:  return 4;
      default:    return 1;
    endcase
  endfunction

  function automatic int unsigned rd_pieces(bm_mode_e m);
    case (m)
      BM_W36_R18: return 2;
      BM_W36_R9:  return 4;
      default:    return 1;
    endcase
  endfunction

  // Lane of the k-th piece in arrival/departure order; lane 0 is least significant.
  function automatic logic [1:0] piece_lane(logic [1:0] k, int unsigned n, logic big);
    logic [1:0] r;
    r = big ? 2'(n - 1 - 32'(k)) : k;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] put_piece(logic [WORD_W-1:0] w,
                                                  logic [WORD_W-1:0] d,
                                                  int unsigned n, logic [1:0] lane);
    logic [WORD_W-1:0] r;
    r = w;
    case (n)
      2:       r[int'(lane[0])*HALF_W +: HALF_W]  = d[HALF_W-1:0];
      4:       r[int'(lane)*SLICE_W +: SLICE_W]   = d[SLICE_W-1:0];
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] get_piece(logic [WORD_W-1:0] w,
                                                  int unsigned n, logic [1:0] lane);
    logic [WORD_W-1:0] r;
    r = '0;
    case (n)
      2:       r[HALF_W-1:0]  = w[int'(lane[0])*HALF_W +: HALF_W];
      4:       r[SLICE_W-1:0] = w[int'(lane)*SLICE_W +: SLICE_W];
      default: r = w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wmf_packer.sv
module wmf_packer
  import wmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bm_mode_e          mode,
  input  logic              big,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              full,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [1:0]        k_q;
  logic [WORD_W-1:0] acc_q;
  logic              accept;
  logic              last;
  int unsigned       n;

  always_comb begin
    n         = wr_pieces(mode);
    accept    = wr_en & ~full;
    last      = (32'(k_q) == n - 1);
    push_word = put_piece(acc_q, wr_data, n, piece_lane(k_q, n, big));
    push      = accept & last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q   <= '0;
      acc_q <= '0;
    end else if (accept) begin
      if (last) begin
        k_q   <= '0;
        acc_q <= '0;
      end else begin
        k_q   <= k_q + 2'd1;
        acc_q <= push_word;
      end
    end
  end
endmodule

// File: rtl/wmf_store.sv
module wmf_store
  import wmf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  assign head  = mem[rd_ptr];
  assign full  = (32'(count) == DEPTH);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wmf_unpacker.sv
module wmf_unpacker
  import wmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bm_mode_e          mode,
  input  logic              big,
  input  logic              rd_en,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic [WORD_W-1:0] rd_data,
  output logic              pop
);
  logic [1:0]  k_q;
  logic        accept;
  logic        last;
  int unsigned n;

  always_comb begin
    n       = rd_pieces(mode);
    accept  = rd_en & ~empty;
    last    = (32'(k_q) == n - 1);
    rd_data = get_piece(head, n, piece_lane(k_q, n, big));
    pop     = accept & last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      k_q <= '0;
    else if (accept) k_q <= last ? 2'd0 : k_q + 2'd1;
  end
endmodule

// File: rtl/width_match_fifo.sv
module width_match_fifo
  import wmf_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_bus_sel,
  input  logic        cfg_big_end,
  input  logic        wr_en,
  input  logic [35:0] wr_data,
  input  logic        rd_en,
  output logic [35:0] rd_data,
  output logic        full,
  output logic        empty
);
  bm_mode_e          mode_q;
  logic              big_q;
  logic              push, pop;
  logic [WORD_W-1:0] push_word, head;
  logic [CNT_W-1:0]  word_count;

  // Configuration is captured only while master reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= legal_mode(cfg_bus_sel);
      big_q  <= cfg_big_end;
    end
  end

  wmf_packer u_pack (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .big(big_q),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .push(push), .push_word(push_word)
  );

  wmf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
    .pop(pop), .head(head), .count(word_count), .full(full), .empty(empty)
  );

  wmf_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .big(big_q),
    .rd_en(rd_en), .empty(empty), .head(head),
    .rd_data(rd_data), .pop(pop)
  );
endmodule

// File: rtl/wmf_checker.sv
module wmf_checker #(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full,
  input logic             empty,
  input logic             push,
  input logic             pop,
  input logic             wr_en,
  input logic             rd_en,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       mode_q,
  input logic             big_q
);
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_q) && $stable(big_q)));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |-> !push);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |-> !pop);

  p_piece_keeps_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !pop && !push) |=> $stable(count));
endmodule

bind width_match_fifo wmf_checker #(.DEPTH(DEPTH)) u_wmf_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .empty(empty),
  .push(push), .pop(pop), .wr_en(wr_en), .rd_en(rd_en),
  .count(word_count), .mode_q(mode_q), .big_q(big_q)
);

// File: tb/width_match_fifo_tb.sv
`timescale 1ns/1ps
module width_match_fifo_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_bus_sel = 3'd0;
  logic        cfg_big_end = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [35:0] rd_data;
  logic        full, empty;

  always #2 clk = ~clk;

  width_match_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bus_sel(cfg_bus_sel), .cfg_big_end(cfg_big_end),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .full(full), .empty(empty)
  );

  int    checks = 0, fails = 0;
  string tag = "R10";
  bit    in_reset = 1'b1, done = 1'b0;

  // Scoreboard model state
  logic [35:0] exp_q[$];
  int          mstore, wk, rk, msel;
  bit          mbig;
  logic [35:0] wacc;

  function automatic int nw(int s); return (s == 3) ? 2 : (s == 4) ? 4 : 1; endfunction
  function automatic int nr(int s); return (s == 1) ? 2 : (s == 2) ? 4 : 1; endfunction
  function automatic logic [35:0] ones(int w);
    return (w >= 36) ? '1 : ((36'd1 << w) - 36'd1);
  endfunction
  function automatic logic [35:0] gen(int i);
    return 36'(i * 36'h9E3779B1) ^ 36'hA5C3F0E17;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_store(logic [35:0] w);
    int rw;
    rw = 36 / nr(msel);
    mstore++;
    for (int i = 0; i < nr(msel); i++) begin
      if (mbig) exp_q.push_back((w >> (36 - (i + 1) * rw)) & ones(rw));
      else      exp_q.push_back((w >> (i * rw)) & ones(rw));
    end
  endtask

  // Monitor: compares flags and data against the model, then applies this edge.
  always @(negedge clk) begin
    bit          was_full;
    logic [35:0] d, e;
    int          ww;
    if (rst_n && !in_reset) begin
      was_full = (mstore == DEPTH);
      chk(empty == (exp_q.size() == 0), tag, "empty flag", 36'(empty), 36'(exp_q.size() == 0));
      chk(full == was_full, tag, "full flag", 36'(full), 36'(was_full));
      if (rd_en && exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk(rd_data === e, tag, "read data", rd_data, e);
        rk++;
        if (rk == nr(msel)) begin rk = 0; mstore--; end
      end
      if (wr_en && !was_full) begin
        ww = 36 / nw(msel);
        d  = wr_data & ones(ww);
        if (nw(msel) == 1) model_store(d);
        else begin
          if (mbig) wacc = (wacc << ww) | d;
          else      wacc = (wacc >> ww) | (d << (36 - ww));
          wk++;
          if (wk == nw(msel)) begin model_store(wacc); wk = 0; wacc = '0; end
        end
      end
    end
  end

  task automatic cyc(bit we, logic [35:0] wd, bit re);
    wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset(int sel, bit big);
    in_reset = 1'b1; rst_n = 1'b0;
    cfg_bus_sel = 3'(sel); cfg_big_end = big;
    repeat (3) @(posedge clk);
    #1;
    exp_q.delete(); mstore = 0; wk = 0; rk = 0; wacc = '0;
    msel = sel; mbig = big;
    rst_n = 1'b1; in_reset = 1'b0;
    @(negedge clk);
    chk(empty === 1'b1, "R10", "empty after reset", 36'(empty), 36'd1);
    chk(full === 1'b0, "R10", "full after reset", 36'(full), 36'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    int n;
    for (int sel = 0; sel < 5; sel++) begin
      for (int b = 0; b < 2; b++) begin
        tag = (sel == 0) ? "R2" : (sel < 3) ? "R3" : "R4";
        do_reset(sel, b[0]);
        for (int i = 0; i < 12; i++) cyc(1'b1, gen(i + sel * 50), 1'b0);
        for (int i = 0; i < 4 * DEPTH + 4; i++) cyc(1'b0, '0, 1'b1);
        for (int i = 0; i < 24; i++) cyc(1'b1, gen(i + 300), (i % 3) != 0);
        for (int i = 0; i < 4 * DEPTH + 4; i++) cyc(1'b0, '0, 1'b1);
      end
    end

    // R1: configuration changes after reset do not alter the latched mode
    do_reset(2, 1'b1);
    tag = "R1";
    cfg_bus_sel = 3'd3; cfg_big_end = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, gen(i + 700), 1'b0);
    for (int i = 0; i < 14; i++) cyc(1'b0, '0, 1'b1);

    // R5: half-gathered word keeps empty high
    do_reset(3, 1'b1);
    tag = "R5";
    cyc(1'b1, gen(800), 1'b0);
    @(negedge clk);
    chk(empty === 1'b1, "R5", "empty with partial word", 36'(empty), 36'd1);
    @(posedge clk); #1;
    cyc(1'b1, gen(801), 1'b0);
    @(negedge clk);
    chk(empty === 1'b0, "R5", "empty after word complete", 36'(empty), 36'd0);
    @(posedge clk); #1;
    cyc(1'b0, '0, 1'b1);

    // R6, R7, R9: fill with 9-bit writes, overrun, single piece read
    do_reset(4, 1'b0);
    tag = "R6";
    n = 4 * DEPTH;
    for (int i = 0; i < n; i++) cyc(1'b1, gen(i + 900), 1'b0);
    @(negedge clk);
    chk(full === 1'b1, "R6", "full at capacity", 36'(full), 36'd1);
    @(posedge clk); #1;
    tag = "R7";
    for (int i = 0; i < 6; i++) cyc(1'b1, gen(i + 990), 1'b0);
    do_reset(1, 1'b1);
    tag = "R9";
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, gen(i + 1100), 1'b0);
    cyc(1'b0, '0, 1'b1);
    @(negedge clk);
    chk(full === 1'b1, "R9", "full after first piece", 36'(full), 36'd1);
    @(posedge clk); #1;
    cyc(1'b1, gen(1200), 1'b0);
    tag = "R7";
    for (int i = 0; i < 2 * DEPTH + 4; i++) cyc(1'b0, '0, 1'b1);

    // R8: reads on empty are dropped
    do_reset(0, 1'b1);
    tag = "R8";
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1);
    cyc(1'b1, gen(1300), 1'b0);
    cyc(1'b1, gen(1301), 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule